// File: doc/BRIEF.md
# IN Endpoint Double-Buffer Status Controller

This block holds the control and status state of one bulk, interrupt or isochronous IN endpoint whose transmit FIFO can hold one or two packets. Software writes an 8-bit control word to commit a loaded packet, drop a queued packet, request a stall or reset the data toggle. The block counts the queued packets and answers each IN token with one of four codes: data, NAK, STALL or a zero-length packet.

The serial interface engine sends each token to the block and reports each packet that has been sent. The block returns the data toggle (DATA0 or DATA1) for the next packet. It also emits a one-cycle FIFO flush pulse, which the FIFO uses to drop a packet or to reset its pointers. A one-cycle interrupt pulse marks each packet that is sent and each stall that is answered. The FIFO storage itself is outside this block.

Top module: `in_ep_status`

## Requirements
- R1: Reset is asynchronous and active low. During and after reset, every bit of `csr_rdata` is 0, `resp_code` is 0 (idle), and `data_tog`, `fifo_flush` and `irq` are 0.
- R2: Writing a word with bit 0 set commits one packet. The packet count goes up by one and saturates at 2 when `dbl_buf_en` is 1, or at 1 when it is 0. Bit 1 of `csr_rdata` reads 1 exactly when the count is nonzero.
- R3: Bit 0 of `csr_rdata` (transmit-ready) reads 1 when the count is nonzero and double buffering is off. With double buffering on, it reads 1 only when both buffers are full. After a commit into an empty double-buffered FIFO, it therefore reads 0 at once, so a second packet can be loaded.
- R4: The response to an IN token appears on `resp_code` in the cycle after the token and lasts one cycle. The codes are 1 = data, 2 = NAK, 3 = STALL and 4 = zero-length packet. In every cycle that follows a cycle without a token, `resp_code` is 0. When no stall applies, a token that finds at least one packet queued gets code 1.
- R5: In bulk/interrupt mode (`iso_mode` = 0), a token with no packet queued and no stall request gets a NAK and sets the underrun flag, bit 2.
- R6: In isochronous mode, a token with no packet queued gets a zero-length packet (code 4) and sets bit 2. The stall request has no effect in this mode.
- R7: Bits 2 and 5 are sticky. A write with the bit at 0 clears it, and a write with the bit at 1 leaves it as it is. When a hardware set and a software clear fall in the same cycle, the set wins.
- R8: Writing bit 3 as 1 removes one queued packet (the count does not go below 0) and pulses `fifo_flush` in the next cycle. Bit 3 always reads 0.
- R9: Bit 4 (stall request) takes the written value and keeps it until the next write. In bulk/interrupt mode, a token that arrives while bit 4 is 1 gets a STALL response. It also sets bit 5, clears the count to 0 (this overrides a commit in the same cycle) and pulses `fifo_flush`.
- R10: A `tx_done` pulse while the count is nonzero lowers the count by one. In bulk/interrupt mode it also flips `data_tog`. A `tx_done` pulse while the count is 0 is ignored.
- R11: Writing bit 6 as 1 sets `data_tog` to 0. This wins over a flip in the same cycle. Bits 6 and 7 always read 0.
- R12: `irq` pulses for one cycle after each accepted `tx_done` and after each STALL response, but only when `int_en` was 1 in the cycle of the event.
- R13: A commit, an accepted send and a flush command in the same cycle combine arithmetically. The result is clamped between 0 and the buffer limit. The clamp is also applied in every cycle when the limit drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| csr_wr | input | 1 | Control word write strobe |
| csr_wdata | input | 8 | Control word written |
| csr_rdata | output | 8 | Status word read back |
| iso_mode | input | 1 | 1 = isochronous, 0 = bulk/interrupt |
| dbl_buf_en | input | 1 | Enables the second packet buffer |
| int_en | input | 1 | Interrupt enable |
| tok_in | input | 1 | IN token received (one-cycle strobe) |
| tx_done | input | 1 | Packet sent (one-cycle strobe) |
| resp_code | output | 3 | Token response code |
| data_tog | output | 1 | Data toggle for the next packet (0 = DATA0) |
| fifo_flush | output | 1 | FIFO drop/reset pulse |
| irq | output | 1 | Interrupt pulse |

## Verification
The status word changes one clock after the write, token or send that caused the change, since it reads straight from the state flops. `resp_code`, `fifo_flush` and `irq` are flops loaded at the edge where the event is seen, so each of them is due in the cycle after the stimulus and lasts one cycle. `data_tog` is also due one cycle after its event. The bench drives inputs one nanosecond after each rising edge and updates a behavioural integer model with those same inputs. It then compares every output against the model one nanosecond after the next edge, so each comparison lands exactly one edge after its stimulus.

// File: rtl/in_ep_pkg.sv
package in_ep_pkg;

  localparam int CSR_W = 8;

  // Control/status word bit positions (software-visible map)
  localparam int B_TXRDY    = 0;
  localparam int B_PRESENT  = 1;
  localparam int B_UNDERRUN = 2;
  localparam int B_DROP     = 3;
  localparam int B_STALLREQ = 4;
  localparam int B_STALLED  = 5;
  localparam int B_TOGCLR   = 6;

  typedef enum logic [2:0] {
    RSP_IDLE  = 3'd0,
    RSP_DATA  = 3'd1,
    RSP_NAK   = 3'd2,
    RSP_STALL = 3'd3,
    RSP_ZLP   = 3'd4
  } rsp_e;

  // Queue depth after one cycle of events, clamped to [0, lim]
  function automatic int next_count(input int cur, input logic add,
                                    input logic sub_tx, input logic sub_fl,
                                    input logic wipe, input int lim);
    int n;
    n = cur;
    if (add)    n = n + 1;
    if (sub_tx) n = n - 1;
    if (sub_fl) n = n - 1;
    if (wipe)   n = 0;
    if (n < 0)   n = 0;
    if (n > lim) n = lim;
    return n;
  endfunction

  // Transmit-ready view of the queue depth
  function automatic logic ready_view(input logic dbl, input int cnt, input int nbuf);
    if (dbl) return (cnt == nbuf);
    return (cnt != 0);
  endfunction

endpackage

// File: rtl/in_ep_pktq.sv
module in_ep_pktq
  import in_ep_pkg::*;
#(
  parameter int NUM_BUF = 2,
  parameter int CNT_W   = $clog2(NUM_BUF + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dbl_en,
  input  logic             commit,
  input  logic             sent,
  input  logic             drop_cmd,
  input  logic             wipe,
  output logic [CNT_W-1:0] cnt,
  output logic             tx_ready
);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;
  int               lim;

  always_comb begin
    lim   = dbl_en ? NUM_BUF : 1;
    cnt_d = CNT_W'(next_count(int'(cnt_q), commit, sent, drop_cmd, wipe, lim));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt      = cnt_q;
  assign tx_ready = ready_view(dbl_en, int'(cnt_q), NUM_BUF);

endmodule

// File: rtl/in_ep_resp.sv
module in_ep_resp
  import in_ep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tok_in,
  input  logic       iso_mode,
  input  logic       stall_req,
  input  logic       have_pkt,
  output logic       ev_data,
  output logic       ev_nak,
  output logic       ev_zlp,
  output logic       ev_stall,
  output logic [2:0] resp_code
);

  rsp_e rsp_d;
  rsp_e rsp_q;

  always_comb begin
    ev_stall = tok_in && !iso_mode && stall_req;
    ev_data  = tok_in && !ev_stall && have_pkt;
    ev_zlp   = tok_in && iso_mode && !have_pkt;
    ev_nak   = tok_in && !iso_mode && !stall_req && !have_pkt;
    rsp_d    = RSP_IDLE;
    if (ev_stall)     rsp_d = RSP_STALL;
    else if (ev_data) rsp_d = RSP_DATA;
    else if (ev_zlp)  rsp_d = RSP_ZLP;
    else if (ev_nak)  rsp_d = RSP_NAK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= RSP_IDLE;
    else        rsp_q <= rsp_d;
  end

  assign resp_code = rsp_q;

endmodule

// File: rtl/in_ep_flags.sv
module in_ep_flags (
  input  logic clk,
  input  logic rst_n,
  input  logic csr_wr,
  input  logic wr_underrun,
  input  logic wr_stallreq,
  input  logic wr_stalled,
  input  logic ev_underrun,
  input  logic ev_stall,
  input  logic ev_sent,
  input  logic ev_drop,
  input  logic ev_tog_clr,
  input  logic iso_mode,
  input  logic int_en,
  output logic underrun,
  output logic stall_req,
  output logic stalled,
  output logic data_tog,
  output logic fifo_flush,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      underrun   <= 1'b0;
      stall_req  <= 1'b0;
      stalled    <= 1'b0;
      data_tog   <= 1'b0;
      fifo_flush <= 1'b0;
      irq        <= 1'b0;
    end else begin
      if (ev_underrun)                 underrun <= 1'b1;
      else if (csr_wr && !wr_underrun) underrun <= 1'b0;

      if (ev_stall)                    stalled <= 1'b1;
      else if (csr_wr && !wr_stalled)  stalled <= 1'b0;

      if (csr_wr) stall_req <= wr_stallreq;

      if (ev_tog_clr)                  data_tog <= 1'b0;
      else if (ev_sent && !iso_mode)   data_tog <= !data_tog;

      fifo_flush <= ev_drop || ev_stall;
      irq        <= int_en && (ev_sent || ev_stall);
    end
  end

endmodule

// File: rtl/in_ep_status.sv
module in_ep_status
  import in_ep_pkg::*;
#(
  parameter int NUM_BUF = 2,
  localparam int CNT_W  = $clog2(NUM_BUF + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  input  logic             iso_mode,
  input  logic             dbl_buf_en,
  input  logic             int_en,
  input  logic             tok_in,
  input  logic             tx_done,
  output logic [2:0]       resp_code,
  output logic             data_tog,
  output logic             fifo_flush,
  output logic             irq
);

  // Named internal events
  logic             ev_commit;
  logic             ev_drop;
  logic             ev_tog_clr;
  logic             ev_sent;
  logic             ev_data;
  logic             ev_nak;
  logic             ev_zlp;
  logic             ev_stall;
  logic [CNT_W-1:0] pkt_cnt;
  logic             tx_ready;
  logic             underrun;
  logic             stall_req;
  logic             stalled;
  logic             unused_wbits;

  assign ev_commit    = csr_wr && csr_wdata[B_TXRDY];
  assign ev_drop      = csr_wr && csr_wdata[B_DROP];
  assign ev_tog_clr   = csr_wr && csr_wdata[B_TOGCLR];
  assign ev_sent      = tx_done && (pkt_cnt != '0);
  assign unused_wbits = ^{csr_wdata[CSR_W-1:B_TOGCLR+1], csr_wdata[B_PRESENT]};

  in_ep_pktq #(.NUM_BUF(NUM_BUF), .CNT_W(CNT_W)) u_pktq (
    .clk      (clk),
    .rst_n    (rst_n),
    .dbl_en   (dbl_buf_en),
    .commit   (ev_commit),
    .sent     (ev_sent),
    .drop_cmd (ev_drop),
    .wipe     (ev_stall),
    .cnt      (pkt_cnt),
    .tx_ready (tx_ready)
  );

  in_ep_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .tok_in    (tok_in),
    .iso_mode  (iso_mode),
    .stall_req (stall_req),
    .have_pkt  (pkt_cnt != '0),
    .ev_data   (ev_data),
    .ev_nak    (ev_nak),
    .ev_zlp    (ev_zlp),
    .ev_stall  (ev_stall),
    .resp_code (resp_code)
  );

  in_ep_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .csr_wr      (csr_wr),
    .wr_underrun (csr_wdata[B_UNDERRUN]),
    .wr_stallreq (csr_wdata[B_STALLREQ]),
    .wr_stalled  (csr_wdata[B_STALLED]),
    .ev_underrun (ev_nak || ev_zlp),
    .ev_stall    (ev_stall),
    .ev_sent     (ev_sent),
    .ev_drop     (ev_drop),
    .ev_tog_clr  (ev_tog_clr),
    .iso_mode    (iso_mode),
    .int_en      (int_en),
    .underrun    (underrun),
    .stall_req   (stall_req),
    .stalled     (stalled),
    .data_tog    (data_tog),
    .fifo_flush  (fifo_flush),
    .irq         (irq)
  );

  always_comb begin
    csr_rdata             = '0;
    csr_rdata[B_TXRDY]    = tx_ready;
    csr_rdata[B_PRESENT]  = (pkt_cnt != '0);
    csr_rdata[B_UNDERRUN] = underrun;
    csr_rdata[B_STALLREQ] = stall_req;
    csr_rdata[B_STALLED]  = stalled;
  end

endmodule

// File: rtl/in_ep_status_chk.sv
module in_ep_status_chk #(
  parameter int NUM_BUF = 2,
  parameter int CNT_W   = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tok_in,
  input logic             iso_mode,
  input logic             int_en,
  input logic             irq,
  input logic [2:0]       resp_code,
  input logic [7:0]       csr_rdata,
  input logic             data_tog,
  input logic [3:0]       ev_vec,
  input logic             ev_tog_clr,
  input logic [CNT_W-1:0] pkt_cnt
);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    int'(pkt_cnt) <= NUM_BUF); // R2

  AST_ONE_RESPONSE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_vec)); // R4

  AST_IDLE_WITHOUT_TOKEN: assert property (@(posedge clk) disable iff (!rst_n)
    !tok_in |=> resp_code == 3'd0); // R4

  AST_NAK_MARKS_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    resp_code == 3'd2 |-> csr_rdata[2]); // R5

  AST_STALL_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    resp_code == 3'd3 |-> (csr_rdata[5] && !csr_rdata[1])); // R9

  AST_ISO_TOG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (iso_mode && !ev_tog_clr) |=> $stable(data_tog)); // R10

  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(int_en)); // R12

endmodule

bind in_ep_status in_ep_status_chk #(.NUM_BUF(NUM_BUF), .CNT_W(CNT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tok_in     (tok_in),
  .iso_mode   (iso_mode),
  .int_en     (int_en),
  .irq        (irq),
  .resp_code  (resp_code),
  .csr_rdata  (csr_rdata),
  .data_tog   (data_tog),
  .ev_vec     ({ev_data, ev_nak, ev_zlp, ev_stall}),
  .ev_tog_clr (ev_tog_clr),
  .pkt_cnt    (pkt_cnt)
);

// File: tb/in_ep_status_tb.sv
`timescale 1ns/1ps
module in_ep_status_tb_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       csr_wr = 1'b0;
  logic [7:0] csr_wdata = 8'h00;
  logic [7:0] csr_rdata;
  logic       iso_mode = 1'b0;
  logic       dbl_buf_en = 1'b0;
  logic       int_en = 1'b1;
  logic       tok_in = 1'b0;
  logic       tx_done = 1'b0;
  logic [2:0] resp_code;
  logic       data_tog;
  logic       fifo_flush;
  logic       irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // behavioural model state
  int m_cnt = 0, m_rsp = 0;
  bit m_und = 0, m_sreq = 0, m_stl = 0, m_tog = 0, m_flp = 0, m_irq = 0;

  always #2 clk = ~clk;

  in_ep_status dut_i (
    .clk(clk), .rst_n(rst_n), .csr_wr(csr_wr), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .iso_mode(iso_mode), .dbl_buf_en(dbl_buf_en),
    .int_en(int_en), .tok_in(tok_in), .tx_done(tx_done), .resp_code(resp_code),
    .data_tog(data_tog), .fifo_flush(fifo_flush), .irq(irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
    end
  endtask

  task automatic model_edge();
    int lim;
    bit has, stl_now, sent, wcommit, wdrop;
    lim     = dbl_buf_en ? 2 : 1;
    has     = (m_cnt > 0);
    stl_now = tok_in && !iso_mode && m_sreq;
    sent    = tx_done && has;
    wcommit = csr_wr && csr_wdata[0];
    wdrop   = csr_wr && csr_wdata[3];
    if (!tok_in)      m_rsp = 0;
    else if (stl_now) m_rsp = 3;
    else if (has)     m_rsp = 1;
    else if (iso_mode) m_rsp = 4;
    else              m_rsp = 2;
    if (tok_in && !has && !stl_now) m_und = 1;
    else if (csr_wr && !csr_wdata[2]) m_und = 0;
    if (stl_now) m_stl = 1;
    else if (csr_wr && !csr_wdata[5]) m_stl = 0;
    if (csr_wr) m_sreq = csr_wdata[4];
    if (csr_wr && csr_wdata[6]) m_tog = 0;
    else if (sent && !iso_mode) m_tog = !m_tog;
    m_flp = wdrop || stl_now;
    m_irq = int_en && (sent || stl_now);
    m_cnt = m_cnt + int'(wcommit) - int'(sent) - int'(wdrop);
    if (stl_now) m_cnt = 0;
    if (m_cnt < 0) m_cnt = 0;
    if (m_cnt > lim) m_cnt = lim;
  endtask

  task automatic compare_all();
    bit rdy;
    rdy = dbl_buf_en ? (m_cnt == 2) : (m_cnt > 0);
    chk("R3 txrdy",    int'(csr_rdata[0]), int'(rdy));
    chk("R2 present",  int'(csr_rdata[1]), int'(m_cnt > 0));
    chk("R7 underrun", int'(csr_rdata[2]), int'(m_und));
    chk("R8 dropbit",  int'(csr_rdata[3]), 0);
    chk("R9 stallreq", int'(csr_rdata[4]), int'(m_sreq));
    chk("R9 stalled",  int'(csr_rdata[5]), int'(m_stl));
    chk("R11 hibits",  int'(csr_rdata[7:6]), 0);
    chk("R4 resp",     int'(resp_code), m_rsp);
    chk("R10 tog",     int'(data_tog), int'(m_tog));
    chk("R8 flush",    int'(fifo_flush), int'(m_flp));
    chk("R12 irq",     int'(irq), int'(m_irq));
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    model_edge();
    compare_all();
  endtask

  task automatic drive(input bit w, input logic [7:0] d, input bit t, input bit x);
    csr_wr = w; csr_wdata = d; tok_in = t; tx_done = x;
    step();
    csr_wr = 1'b0; csr_wdata = 8'h00; tok_in = 1'b0; tx_done = 1'b0;
  endtask

  task automatic idle();
    drive(0, 8'h00, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R1 rdata", int'(csr_rdata), 0);
    chk("R1 outs", int'({resp_code, data_tog, fifo_flush, irq}), 0);
    rst_n = 1'b1;
    idle();
    chk("R1 after release", int'(csr_rdata), 0);

    // single buffer commit and saturation
    drive(1, 8'h01, 0, 0);
    chk("R2 commit", int'(csr_rdata), 8'h03);
    drive(1, 8'h01, 0, 0);
    chk("R2 single sat", int'(csr_rdata), 8'h03);

    // data response and send
    drive(0, 8'h00, 1, 0);
    chk("R4 data", int'(resp_code), 1);
    drive(0, 8'h00, 0, 1);
    chk("R10 dec", int'(csr_rdata), 8'h00);
    chk("R10 flip", int'(data_tog), 1);
    chk("R12 irq sent", int'(irq), 1);
    idle();
    chk("R12 pulse", int'(irq), 0);

    // NAK and sticky underrun
    drive(0, 8'h00, 1, 0);
    chk("R5 nak", int'(resp_code), 2);
    chk("R5 underrun", int'(csr_rdata[2]), 1);
    drive(1, 8'h04, 0, 0);
    chk("R7 keep", int'(csr_rdata[2]), 1);
    drive(1, 8'h00, 0, 0);
    chk("R7 clear", int'(csr_rdata[2]), 0);

    // double buffer
    dbl_buf_en = 1'b1;
    drive(1, 8'h01, 0, 0);
    chk("R3 dbl one", int'(csr_rdata[1:0]), 2'b10);
    drive(1, 8'h01, 0, 0);
    chk("R3 dbl full", int'(csr_rdata[1:0]), 2'b11);
    drive(1, 8'h01, 0, 0);
    chk("R2 dbl sat", int'(csr_rdata[1:0]), 2'b11);
    drive(1, 8'h08, 0, 0);
    chk("R8 drop one", int'(csr_rdata[1:0]), 2'b10);
    chk("R8 pulse", int'(fifo_flush), 1);
    drive(1, 8'h08, 0, 0);
    chk("R8 drop two", int'(csr_rdata[1:0]), 2'b00);
    drive(1, 8'h08, 0, 0);
    chk("R8 floor", int'(csr_rdata[1:0]), 2'b00);

    // combined events
    drive(1, 8'h01, 0, 0);
    drive(1, 8'h01, 0, 0);
    drive(1, 8'h09, 0, 1);
    chk("R13 combine", int'(csr_rdata[1:0]), 2'b10);
    chk("R13 tog", int'(data_tog), 0);
    drive(0, 8'h00, 0, 1);
    drive(0, 8'h00, 0, 1);
    chk("R10 ignore cnt", int'(csr_rdata[1:0]), 2'b00);
    chk("R10 ignore tog", int'(data_tog), 1);
    chk("R10 ignore irq", int'(irq), 0);

    // stall
    drive(1, 8'h10, 0, 0);
    drive(1, 8'h11, 0, 0);
    chk("R9 hold", int'(csr_rdata), 8'h12);
    drive(0, 8'h00, 1, 0);
    chk("R9 stall", int'(resp_code), 3);
    chk("R9 word", int'(csr_rdata), 8'h30);
    chk("R9 flush", int'(fifo_flush), 1);
    chk("R12 irq stall", int'(irq), 1);
    idle();
    chk("R9 persist", int'(csr_rdata[4]), 1);
    drive(1, 8'h00, 0, 0);
    chk("R9 released", int'(csr_rdata), 8'h00);

    // isochronous
    iso_mode = 1'b1;
    drive(1, 8'h10, 0, 0);
    drive(0, 8'h00, 1, 0);
    chk("R6 zlp", int'(resp_code), 4);
    chk("R6 underrun", int'(csr_rdata), 8'h14);
    drive(1, 8'h11, 0, 0);
    drive(0, 8'h00, 1, 0);
    chk("R6 iso data", int'(resp_code), 1);
    drive(0, 8'h00, 0, 1);
    chk("R10 iso tog", int'(data_tog), 1);
    drive(1, 8'h00, 0, 0);

    // toggle clear
    drive(1, 8'h40, 0, 0);
    chk("R11 clear", int'(data_tog), 0);
    iso_mode = 1'b0;
    drive(1, 8'h01, 0, 0);
    drive(0, 8'h00, 0, 1);
    chk("R10 bulk flip", int'(data_tog), 1);
    drive(1, 8'h01, 0, 0);
    drive(1, 8'h40, 0, 1);
    chk("R11 wins", int'(data_tog), 0);

    // mixed stimulus, model compared every cycle
    for (int i = 0; i < 600; i++) begin
      if (i % 60 == 0) begin
        iso_mode   = 1'($urandom_range(0, 1));
        dbl_buf_en = 1'($urandom_range(0, 1));
        int_en     = 1'($urandom_range(0, 1));
      end
      drive($urandom_range(0, 2) == 0, 8'($urandom), $urandom_range(0, 2) == 0,
            $urandom_range(0, 2) == 0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule